// File: doc/BRIEF.md
# Slave Parallel Configuration and Debug Port

This block is the target end of a synchronous parallel bus that a host uses both to stream configuration data into a device and to peek and poke a set of internal debug registers. On each rising clock edge at which the select input is high, a 2-bit access-type field says what the data lines carry. The four meanings are: a piece of a register address, a register read, a register write, or a configuration word.

Debug registers are arranged as a number of identical rows. A 32-bit address names a row in its upper half and a register in its lower half. One reserved row value reaches every row at once on a write.

Configuration words are gated by a device identifier. The first configuration word of a stream is a header whose low byte is the identifier the stream is meant for. The words that follow are passed on only when that identifier equals the identifier strapped on the chip's pins or is the all-devices value. A byte-mode input narrows the bus to its 8 low lines.

Top module: `cfg_slave_port`

## Requirements
- R1: When `sel` is low at a rising edge, nothing changes: no register is written, the address is not altered, and `rd_valid` and `cfg_valid` stay low the next cycle.
- R2: An access with type 2'b00 loads one address piece. In 16-bit mode two pieces make the 32-bit address, with bits [15:0] first and then bits [31:16]. The piece counter restarts at the low piece after any access of another type.
- R3: An access with type 2'b10 writes the data lines into the register named by the current address. Address bits [31:16] pick the row (0 to ROWS-1) and bits [15:0] pick the register (0 to REGS-1).
- R4: A write whose row field is 16'h00FF stores the value into the addressed register of every row.
- R5: An access with type 2'b01 puts the addressed register on `rd_data` with `rd_valid` high in the following cycle only. While `rd_valid` is low, `rd_data` is zero. A read with row field 16'h00FF returns row 0.
- R6: If the row field is neither a valid row nor 16'h00FF, or the register field is REGS or above, a write changes nothing and a read returns zero with `rd_valid` high. All 16 bits of each field are compared.
- R7: In byte mode (`byte_mode` high) only `bus_in[7:0]` is used. The address takes four pieces, least significant byte first. A write stores the byte with the upper 8 bits cleared. `rd_data[15:8]` reads as zero.
- R8: The first type-2'b11 access after reset, or after any access of another type, is a header. Its `bus_in[7:0]` is the stream identifier, and it produces no `cfg_valid`.
- R9: A type-2'b11 access after a header appears on `cfg_data` with `cfg_valid` high the next cycle when the stream identifier equals {4'h0, `chip_id`} or is 8'hFF. In byte mode the word is zero-extended from `bus_in[7:0]`.
- R10: After a header that does not match, `id_mismatch` is high from the next cycle and following words are dropped. The flag holds until the next header, and a matching header clears it.
- R11: After reset every register, the address and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Active-high select; an access happens at an edge where it is high |
| acc_type | input | 2 | 00 address piece, 01 read, 10 write, 11 configuration word |
| bus_in | input | 16 | Data lines from the host |
| byte_mode | input | 1 | High selects the 8-bit bus |
| chip_id | input | 4 | Pin-strapped device identifier |
| rd_data | output | 16 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Marks read data one cycle after a read access |
| cfg_valid | output | 1 | Marks an accepted configuration word |
| cfg_data | output | 16 | Accepted configuration word |
| id_mismatch | output | 1 | Last header named another device |

## Verification
Every row and register index, including one past each end, is written with a value computed from its coordinates and then read back. This separates row and register decoding faults from faults in the range checks. Broadcast writes, a row field with nonzero upper bits, and a half-loaded address followed by another access type show whether broadcast works, whether the full field is compared, and whether the piece counter restarts. The identifier gate is swept over all 16 chip identifiers against all 256 header values, which tells exact matches, the all-devices value and upper-nibble mismatches apart. Byte-mode passes repeat the address, write, read and configuration paths to expose use of the upper lines.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 32;
    localparam int HALF_W = ADDR_W / 2;

    typedef enum logic [1:0] {
        ACC_ADDR = 2'b00,
        ACC_RD   = 2'b01,
        ACC_WR   = 2'b10,
        ACC_CFG  = 2'b11
    } acc_e;
endpackage

// File: rtl/cfgp_addr_asm.sv
module cfgp_addr_asm
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [1:0]        acc_type,
    input  logic              narrow,
    input  logic [BUS_W-1:0]  wdata,
    output logic [ADDR_W-1:0] addr
);
    localparam int BYTES  = ADDR_W / 8;
    localparam int HALVES = ADDR_W / BUS_W;
    localparam int PTR_W  = $clog2(BYTES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [PTR_W-1:0]  ptr;
    } asm_t;

    asm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (acc_type == ACC_ADDR) begin
                if (narrow) begin
                    st_d.addr[{st_q.ptr, 3'b000} +: 8] = wdata[7:0];
                    st_d.ptr = (st_q.ptr == PTR_W'(BYTES - 1)) ? '0 : st_q.ptr + 1'b1;
                end else begin
                    st_d.addr[{st_q.ptr[0], 4'b0000} +: BUS_W] = wdata;
                    st_d.ptr = (st_q.ptr >= PTR_W'(HALVES - 1)) ? '0 : st_q.ptr + 1'b1;
                end
            end else begin
                st_d.ptr = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr = st_q.addr;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> $stable(addr)); // R1
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter int          ROWS      = 9,
    parameter int          REGS      = 4,
    parameter logic [15:0] BCAST_ROW = 16'h00FF
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [15:0]      row,
    input  logic [15:0]      ridx,
    input  logic             narrow,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             rvld
);
    typedef struct packed {
        logic             vld;
        logic [BUS_W-1:0] data;
    } rd_t;

    logic [BUS_W-1:0] mem_d [ROWS][REGS];
    logic [BUS_W-1:0] mem_q [ROWS][REGS];
    logic [ROWS-1:0]  row_hit;
    logic [BUS_W-1:0] wval;
    logic [15:0]      rrow;
    rd_t              rs_d, rs_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row_hit
        assign row_hit[r] = (row == 16'(r)) || (row == BCAST_ROW);
    end

    always_comb begin
        mem_d = mem_q;
        wval  = narrow ? {8'h00, wdata[7:0]} : wdata;
        for (int r = 0; r < ROWS; r++) begin
            for (int g = 0; g < REGS; g++) begin
                if (wr_en && row_hit[r] && ridx == 16'(g)) mem_d[r][g] = wval;
            end
        end
        rrow       = (row == BCAST_ROW) ? 16'd0 : row;
        rs_d.vld   = rd_en;
        rs_d.data  = '0;
        if (rd_en) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int g = 0; g < REGS; g++) begin
                    if (rrow == 16'(r) && ridx == 16'(g)) rs_d.data = mem_q[r][g];
                end
            end
            if (narrow) rs_d.data[15:8] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
            for (int r = 0; r < ROWS; r++)
                for (int g = 0; g < REGS; g++)
                    mem_q[r][g] <= '0;
        end else begin
            rs_q  <= rs_d;
            mem_q <= mem_d;
        end
    end

    assign rdata = rs_q.data;
    assign rvld  = rs_q.vld;

    AST_RVLD_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rvld |-> $past(rd_en)); // R5
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rvld |-> rdata == '0); // R5
    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rvld && $past(narrow) |-> rdata[15:8] == 8'h00); // R7
    AST_BCAST_ALL_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && row == BCAST_ROW && ridx == 16'd0) |-> mem_q[0][0] == mem_q[ROWS-1][0]); // R4
endmodule

// File: rtl/cfgp_cfg_gate.sv
module cfgp_cfg_gate
    import cfgp_pkg::*;
#(
    parameter int         ID_W     = 4,
    parameter logic [7:0] BCAST_ID = 8'hFF
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [1:0]       acc_type,
    input  logic             narrow,
    input  logic [BUS_W-1:0] wdata,
    input  logic [ID_W-1:0]  chip_id,
    output logic             cfg_vld,
    output logic [BUS_W-1:0] cfg_data,
    output logic             mismatch
);
    localparam int SID_W = 8;

    typedef struct packed {
        logic             hdr_pend;
        logic             match;
        logic             mismatch;
        logic             vld;
        logic [BUS_W-1:0] data;
    } gate_t;

    gate_t            st_d, st_q;
    logic [SID_W-1:0] own_id;
    logic             id_ok;

    assign own_id = {{(SID_W-ID_W){1'b0}}, chip_id};
    assign id_ok  = (wdata[7:0] == BCAST_ID) || (wdata[7:0] == own_id);

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.data = '0;
        if (sel) begin
            if (acc_type == ACC_CFG) begin
                if (st_q.hdr_pend) begin
                    st_d.hdr_pend = 1'b0;
                    st_d.match    = id_ok;
                    st_d.mismatch = !id_ok;
                end else if (st_q.match) begin
                    st_d.vld  = 1'b1;
                    st_d.data = narrow ? {8'h00, wdata[7:0]} : wdata;
                end
            end else begin
                st_d.hdr_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.hdr_pend <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_vld  = st_q.vld;
    assign cfg_data = st_q.data;
    assign mismatch = st_q.mismatch;

    AST_CFG_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_vld |-> $past(sel && acc_type == ACC_CFG)); // R9
    AST_HDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && acc_type == ACC_CFG && st_q.hdr_pend) |-> !cfg_vld); // R8
    AST_DROP_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_vld |-> !mismatch); // R10
endmodule

// File: rtl/cfg_slave_port.sv
module cfg_slave_port
    import cfgp_pkg::*;
#(
    parameter int          ROWS      = 9,
    parameter int          REGS      = 4,
    parameter int          ID_W      = 4,
    parameter logic [15:0] BCAST_ROW = 16'h00FF,
    parameter logic [7:0]  BCAST_ID  = 8'hFF
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic [1:0]  acc_type,
    input  logic [15:0] bus_in,
    input  logic        byte_mode,
    input  logic [3:0]  chip_id,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic        cfg_valid,
    output logic [15:0] cfg_data,
    output logic        id_mismatch
);
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic              rd_en;

    assign wr_en = sel && (acc_type == ACC_WR);
    assign rd_en = sel && (acc_type == ACC_RD);

    cfgp_addr_asm u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .acc_type (acc_type),
        .narrow   (byte_mode),
        .wdata    (bus_in),
        .addr     (addr)
    );

    cfgp_regfile #(
        .ROWS      (ROWS),
        .REGS      (REGS),
        .BCAST_ROW (BCAST_ROW)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .row    (addr[ADDR_W-1:HALF_W]),
        .ridx   (addr[HALF_W-1:0]),
        .narrow (byte_mode),
        .wdata  (bus_in),
        .rdata  (rd_data),
        .rvld   (rd_valid)
    );

    cfgp_cfg_gate #(
        .ID_W     (ID_W),
        .BCAST_ID (BCAST_ID)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .acc_type (acc_type),
        .narrow   (byte_mode),
        .wdata    (bus_in),
        .chip_id  (chip_id),
        .cfg_vld  (cfg_valid),
        .cfg_data (cfg_data),
        .mismatch (id_mismatch)
    );

    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> !rd_valid && !cfg_valid); // R1
endmodule

// File: tb/tb_cfg_slave_port.sv
module tb_cfg_slave_port;
    localparam int CLK_P = 10;
    localparam int ROWS  = 9;
    localparam int REGS  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic [1:0]  acc_type = 2'b00;
    logic [15:0] bus_in = 16'h0;
    logic        byte_mode = 1'b0;
    logic [3:0]  chip_id = 4'h0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        cfg_valid;
    logic [15:0] cfg_data;
    logic        id_mismatch;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [15:0] mdl [ROWS][REGS];

    always #(CLK_P/2) clk = ~clk;

    cfg_slave_port dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .acc_type(acc_type), .bus_in(bus_in),
        .byte_mode(byte_mode), .chip_id(chip_id), .rd_data(rd_data), .rd_valid(rd_valid),
        .cfg_valid(cfg_valid), .cfg_data(cfg_data), .id_mismatch(id_mismatch)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] t, input logic [15:0] d);
        sel = 1'b1; acc_type = t; bus_in = d;
        @(negedge clk);
        sel = 1'b0; acc_type = 2'b00; bus_in = 16'h0;
    endtask

    task automatic set_addr(input logic [15:0] row, input logic [15:0] rg);
        if (byte_mode) begin
            acc(2'b00, {8'h00, rg[7:0]});  acc(2'b00, {8'h00, rg[15:8]});
            acc(2'b00, {8'h00, row[7:0]}); acc(2'b00, {8'h00, row[15:8]});
        end else begin
            acc(2'b00, rg); acc(2'b00, row);
        end
    endtask

    task automatic wr(input logic [15:0] row, input logic [15:0] rg, input logic [15:0] d);
        logic [15:0] v;
        v = byte_mode ? {8'h00, d[7:0]} : d;
        set_addr(row, rg);
        acc(2'b10, d);
        for (int r = 0; r < ROWS; r++)
            for (int g = 0; g < REGS; g++)
                if ((row == 16'(r) || row == 16'h00FF) && rg == 16'(g)) mdl[r][g] = v;
    endtask

    function automatic logic [15:0] exp_rd(input logic [15:0] row, input logic [15:0] rg);
        logic [15:0] rr, v;
        rr = (row == 16'h00FF) ? 16'd0 : row;
        v = 16'h0;
        for (int r = 0; r < ROWS; r++)
            for (int g = 0; g < REGS; g++)
                if (rr == 16'(r) && rg == 16'(g)) v = mdl[r][g];
        if (byte_mode) v[15:8] = 8'h00;
        return v;
    endfunction

    task automatic rd_chk(input string tag, input logic [15:0] row, input logic [15:0] rg);
        set_addr(row, rg);
        acc(2'b01, 16'h0);
        chk({tag, " rd_valid"}, {15'h0, rd_valid}, 16'h1);
        chk({tag, " rd_data"}, rd_data, exp_rd(row, rg));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int g = 0; g < REGS; g++) mdl[r][g] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 rd_valid", {15'h0, rd_valid}, 16'h0);
        chk("R11 rd_data", rd_data, 16'h0);
        chk("R11 cfg_valid", {15'h0, cfg_valid}, 16'h0);
        chk("R11 id_mismatch", {15'h0, id_mismatch}, 16'h0);
        acc(2'b01, 16'h0);
        chk("R11 addr zero reads reg0", {15'h0, rd_valid}, 16'h1);
        chk("R11 reg zero", rd_data, 16'h0);
        for (int r = 0; r < ROWS; r++)
            for (int g = 0; g < REGS; g++) rd_chk("R11 sweep", 16'(r), 16'(g));

        // R3 R6 sweep writes over all coordinates, one past each end
        for (int r = 0; r <= ROWS; r++)
            for (int g = 0; g <= REGS; g++)
                wr(16'(r), 16'(g), 16'((r * 37 + g * 11 + 1) * 97));
        for (int r = 0; r <= ROWS; r++)
            for (int g = 0; g <= REGS; g++) rd_chk("R3 R6 readback", 16'(r), 16'(g));

        // R5 valid for one cycle only
        rd_chk("R5 single", 16'd2, 16'd1);
        @(negedge clk);
        chk("R5 rd_valid drops", {15'h0, rd_valid}, 16'h0);
        chk("R5 rd_data quiet", rd_data, 16'h0);
        for (int g = 0; g < REGS; g++) rd_chk("R5 bcast read row0", 16'h00FF, 16'(g));

        // R6 full row field compared
        wr(16'h0100, 16'd0, 16'hDEAD);
        rd_chk("R6 high row ignored", 16'd0, 16'd0);
        wr(16'd1, 16'h0100, 16'hDEAD);
        rd_chk("R6 high reg ignored", 16'd1, 16'd0);

        // R1 select low: no write, no address change, no outputs
        set_addr(16'd3, 16'd2);
        acc_type = 2'b10; bus_in = 16'h5555; @(negedge clk);
        acc_type = 2'b00; bus_in = 16'h0007; @(negedge clk);
        acc_type = 2'b11; bus_in = 16'h00FF; @(negedge clk);
        chk("R1 no cfg_valid", {15'h0, cfg_valid}, 16'h0);
        acc_type = 2'b01; @(negedge clk);
        chk("R1 no rd_valid", {15'h0, rd_valid}, 16'h0);
        acc_type = 2'b00; bus_in = 16'h0;
        acc(2'b01, 16'h0);
        chk("R1 addr and reg unchanged", rd_data, mdl[3][2]);

        // R4 broadcast writes
        for (int g = 0; g < REGS; g++) wr(16'h00FF, 16'(g), 16'(16'hA000 + g * 257));
        for (int r = 0; r < ROWS; r++)
            for (int g = 0; g < REGS; g++) rd_chk("R4 bcast", 16'(r), 16'(g));
        wr(16'd4, 16'd3, 16'h1234);

        // R2 piece counter restarts after other access type
        acc(2'b00, 16'h0002);
        acc(2'b01, 16'h0);
        set_addr(16'd4, 16'd3);
        acc(2'b01, 16'h0);
        chk("R2 restart", rd_data, 16'h1234);
        acc(2'b00, 16'h0003); acc(2'b00, 16'h0004); acc(2'b00, 16'h0001); acc(2'b00, 16'h0002);
        acc(2'b01, 16'h0);
        chk("R2 wrap to low piece", rd_data, mdl[2][1]);

        // R7 byte mode
        byte_mode = 1'b1;
        wr(16'd2, 16'd3, 16'hBEEF);
        rd_chk("R7 byte write", 16'd2, 16'd3);
        chk("R7 stored low byte", rd_data, 16'h00EF);
        for (int r = 0; r < ROWS; r++) rd_chk("R7 byte read", 16'(r), 16'd1);
        rd_chk("R7 byte bcast row", 16'h00FF, 16'd0);

        // R9 byte-mode configuration words
        chip_id = 4'h6;
        acc(2'b01, 16'h0);
        acc(2'b11, 16'hAA06);
        chk("R8 byte header silent", {15'h0, cfg_valid}, 16'h0);
        chk("R10 byte header match", {15'h0, id_mismatch}, 16'h0);
        acc(2'b11, 16'hAB5A);
        chk("R9 byte cfg_valid", {15'h0, cfg_valid}, 16'h1);
        chk("R9 byte cfg_data", cfg_data, 16'h005A);
        byte_mode = 1'b0;

        // R8 R9 R10 identifier sweep
        for (int c = 0; c < 16; c++) begin
            chip_id = 4'(c);
            for (int id = 0; id < 256; id++) begin
                logic ok;
                logic [15:0] dw;
                ok = (id == 255) || (id == c);
                dw = 16'(c * 4099 + id * 13 + 7);
                acc(2'b01, 16'h0);
                acc(2'b11, {8'h5C, 8'(id)});
                chk("R8 header no cfg_valid", {15'h0, cfg_valid}, 16'h0);
                chk("R10 flag after header", {15'h0, id_mismatch}, {15'h0, !ok});
                acc(2'b11, dw);
                chk("R9 cfg_valid", {15'h0, cfg_valid}, {15'h0, ok});
                chk("R9 cfg_data", cfg_data, ok ? dw : 16'h0);
                acc(2'b11, ~dw);
                chk("R10 flag held", {15'h0, id_mismatch}, {15'h0, !ok});
                chk("R9 second word", cfg_data, ok ? ~dw : 16'h0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule